// File: doc/BRIEF.md
# SPI ADC Channel Scan Controller

This block is an SPI master for a multi-channel successive-approximation ADC that talks in 16-bit frames. Software presents a channel-enable mask, an input-range select and a resolution code, then pulses `start`. The controller walks the enabled channels from lowest to highest. For each one it builds a 12-bit control word, places it in the top of a 16-bit frame and shifts it out most significant bit first.

Commands and results are pipelined. The result of a conversion comes back in the frame that follows its command, so that frame also carries the next command. A scan of n channels therefore takes n+1 frames, and the last frame sends all zeros only to collect the final result. Every returned frame carries a 4-bit channel tag. A frame whose tag does not match the channel that was requested is dropped and raises an error flag. Matching samples are right-aligned and packed into an output array by scan slot. When the scan ends, a count of valid slots and a one-cycle `done` pulse are presented.

Top module: `adc_scan_ctrl`

## Requirements
- R1: Each command frame equals the 12-bit control word shifted left by 4. In the control word, bit 11 is 1, the channel number sits at bit 6 and up, bits 5:4 are 2'b11, bits 10 and 3 are 0, bit 1 equals `rangeSel` as latched at start, bit 0 is 1, and bits 9 (for 8 channels), 2 and the low 4 frame bits are 0.
- R2: SCLK rests high whenever chip select is deasserted. MOSI changes only when SCLK falls. MISO is sampled on the rising SCLK edge. Chip select stays high for at least two SCLK periods between consecutive frames of a scan.
- R3: Enabled channels are commanded in ascending channel order. A scan of n enabled channels uses exactly n+1 frames. Frame k carries the command for the k-th enabled channel, and the final frame is 16'h0000.
- R4: The result for a command is taken from the next frame. With bits 11:0 of that frame as a 12-bit raw field, resolution code 0 gives raw[11:4] (8 bits), code 1 gives raw[11:2] (10 bits) and code 2 gives raw[11:0] (12 bits). Each sample is stored zero-extended in a 12-bit slot.
- R5: When bits 15:12 of a result frame differ from the requested channel number, `scanError` is set. The sample is not stored and `resCount` does not advance. Later matching results fill the next free slot.
- R6: Slot s of `results` (bits 12s+11:12s) holds the s-th stored sample. `resCount` gives the number of stored samples, and slots at or above it read zero. An accepted start clears the slots, the count and the error flag.
- R7: `busy` rises in the cycle after an accepted start with a non-empty mask. It falls after the chip-select gap that follows the final frame, and `done` is high for exactly that one cycle.
- R8: A `start` pulse while `busy` is high is ignored. The scan in progress keeps its frame count and results, and only one `done` pulse results.
- R9: With an all-zero mask, `done` is high in the cycle after `start`. No frame is sent, `busy` stays low, and `resCount` and `scanError` read 0.
- R10: After reset, chip select and SCLK are high, `busy` and `done` are low, and `resCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle scan request |
| chanMask | input | NUM_CH | Channel enable mask, bit i enables channel i |
| rangeSel | input | 1 | 1: 0..Vref range, 0: 0..2*Vref range |
| resSel | input | 2 | Resolution code: 0 = 8, 1 = 10, 2 = 12 bits |
| spiMiso | input | 1 | Serial data from the converter |
| spiSclk | output | 1 | Serial clock, idle high |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data to the converter |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| scanError | output | 1 | At least one channel tag mismatched in the last scan |
| resCount | output | $clog2(NUM_CH+1) | Number of valid result slots |
| results | output | NUM_CH*12 | Packed result slots, slot 0 in the low bits |

## Verification
The hardest case to reach is a tag mismatch in the middle of a scan, because a well-behaved converter never returns one. The bench's converter model can be told to corrupt the tag for one chosen channel. This exercises both the dropped-sample path and the packing of later samples into earlier slots. It also confirms, through the frame log, that the pipelined command order does not change.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int FRAME_W = 16;
  localparam int CMD_W   = 12;
  localparam int TAG_W   = 4;
  localparam int SLOT_W  = 12;

  // strobes from the sequencer to the datapath, at most one shift action per cycle
  typedef struct packed {
    logic latchCfg;  // accepted start: capture settings, clear results
    logic loadCmd;   // frame begins: load command into transmit shifter
    logic shiftOut;  // SCLK falling: present next MOSI bit
    logic sampleIn;  // SCLK rising: capture MISO
    logic storeRes;  // frame complete: check tag, store sample
  } scanStrobe_t;

endpackage

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int CLK_DIV     = 2,
  parameter int CS_GAP_SCLK = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [NUM_CH-1:0] chanMask,
  output scanStrobe_t       strobe,
  output logic [CH_W-1:0]   cmdChan,
  output logic              cmdValid,
  output logic              spiSclk,
  output logic              spiCsN,
  output logic              busy,
  output logic              done
);

  localparam int DIV_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int GAP_CYC = CS_GAP_SCLK * 2 * CLK_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_FRAME, S_GAP} seqState_t;

  seqState_t         state;
  logic [NUM_CH-1:0] remMask;
  logic [DIV_W-1:0]  divCnt;
  logic [4:0]        bitCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic              sclkQ;
  logic              csNQ;
  logic              lastFrame;
  logic              doneQ;
  logic              phaseEnd;
  logic [NUM_CH-1:0] pickHot;

  // lowest remaining enabled channel
  always_comb begin
    cmdValid = 1'b0;
    cmdChan  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (remMask[i]) begin
        cmdValid = 1'b1;
        cmdChan  = CH_W'(i);
      end
    end
  end

  always_comb begin
    pickHot = '0;
    pickHot[cmdChan] = cmdValid;
  end

  assign phaseEnd = (divCnt == DIV_W'(CLK_DIV - 1));

  always_comb begin
    strobe = '0;
    unique case (state)
      S_IDLE:  strobe.latchCfg = start;
      S_LOAD:  strobe.loadCmd  = 1'b1;
      S_FRAME: begin
        if (phaseEnd) begin
          if (sclkQ) begin
            if (bitCnt == 5'd16) strobe.storeRes = 1'b1;
            else if (bitCnt != 5'd0) strobe.shiftOut = 1'b1;
          end else begin
            strobe.sampleIn = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      remMask   <= '0;
      divCnt    <= '0;
      bitCnt    <= '0;
      gapCnt    <= '0;
      sclkQ     <= 1'b1;
      csNQ      <= 1'b1;
      lastFrame <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            remMask <= chanMask;
            if (chanMask == '0) doneQ <= 1'b1;
            else                state <= S_LOAD;
          end
        end
        S_LOAD: begin
          remMask   <= remMask & ~pickHot;
          lastFrame <= !cmdValid;
          csNQ      <= 1'b0;
          sclkQ     <= 1'b1;
          divCnt    <= '0;
          bitCnt    <= '0;
          state     <= S_FRAME;
        end
        S_FRAME: begin
          if (phaseEnd) begin
            divCnt <= '0;
            if (sclkQ) begin
              if (bitCnt == 5'd16) begin
                csNQ   <= 1'b1;
                gapCnt <= '0;
                state  <= S_GAP;
              end else begin
                sclkQ <= 1'b0;
              end
            end else begin
              sclkQ  <= 1'b1;
              bitCnt <= bitCnt + 5'd1;
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        S_GAP: begin
          if (gapCnt == GAP_W'(GAP_CYC - 1)) begin
            if (lastFrame) begin
              state <= S_IDLE;
              doneQ <= 1'b1;
            end else begin
              state <= S_LOAD;
            end
          end else begin
            gapCnt <= gapCnt + GAP_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign spiSclk = sclkQ;
  assign spiCsN  = csNQ;
  assign busy    = (state != S_IDLE);
  assign done    = doneQ;

  // R2: clock rests high outside a frame
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> spiSclk)
    else $error("p_sclk_idle_r2");

  // R7: done marks the cycle in which busy drops
  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done)
    else $error("p_done_at_end_r7");

  // R8: a start during a scan does not end or restart it early
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !(state == S_GAP && lastFrame)) |=> busy)
    else $error("p_ignore_start_r8");

  // R9: empty mask finishes at once without a frame
  p_empty_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && chanMask == '0) |=> (done && !busy && spiCsN))
    else $error("p_empty_mask_r9");

endmodule

// File: rtl/adc_scan_datapath.sv
module adc_scan_datapath
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  scanStrobe_t              strobe,
  input  logic [CH_W-1:0]          cmdChan,
  input  logic                     cmdValid,
  input  logic                     rangeSel,
  input  logic [1:0]               resSel,
  input  logic                     spiMiso,
  output logic                     spiMosi,
  output logic                     scanError,
  output logic [CNT_W-1:0]         resCount,
  output logic [NUM_CH*SLOT_W-1:0] results
);

  logic               rangeQ;
  logic [1:0]         resQ;
  logic [FRAME_W-1:0] txShift;
  logic [FRAME_W-1:0] rxShift;
  logic [CH_W-1:0]    lastCh;
  logic               lastValid;
  logic [CH_W-1:0]    expCh;
  logic               expValid;
  logic [CNT_W-1:0]   countQ;
  logic               errQ;
  logic [CMD_W-1:0]   cmdWord;
  logic [SLOT_W-1:0]  sample;
  logic               tagMatch;
  logic               storeOk;

  // control word: write enable, channel, normal power, sequencing off, range, binary coding
  always_comb begin
    cmdWord = '0;
    cmdWord[11]          = 1'b1;
    cmdWord[10]          = 1'b0;
    cmdWord[6 +: CH_W]   = cmdChan;
    cmdWord[5:4]         = 2'b11;
    cmdWord[3]           = 1'b0;
    cmdWord[1]           = rangeQ;
    cmdWord[0]           = 1'b1;
  end

  always_comb begin
    unique case (resQ)
      2'd0:    sample = {4'b0, rxShift[11:4]};
      2'd1:    sample = {2'b0, rxShift[11:2]};
      default: sample = rxShift[11:0];
    endcase
  end

  assign tagMatch = (rxShift[15:12] == TAG_W'(expCh));
  assign storeOk  = strobe.storeRes && expValid && tagMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rangeQ    <= 1'b0;
      resQ      <= 2'd2;
      txShift   <= '0;
      rxShift   <= '0;
      lastCh    <= '0;
      lastValid <= 1'b0;
      expCh     <= '0;
      expValid  <= 1'b0;
      countQ    <= '0;
      errQ      <= 1'b0;
    end else begin
      if (strobe.latchCfg) begin
        rangeQ    <= rangeSel;
        resQ      <= resSel;
        countQ    <= '0;
        errQ      <= 1'b0;
        lastValid <= 1'b0;
        expValid  <= 1'b0;
      end
      if (strobe.loadCmd) begin
        txShift   <= cmdValid ? {cmdWord, 4'b0} : '0;
        expCh     <= lastCh;
        expValid  <= lastValid;
        lastCh    <= cmdChan;
        lastValid <= cmdValid;
      end
      if (strobe.shiftOut) txShift <= {txShift[FRAME_W-2:0], 1'b0};
      if (strobe.sampleIn) rxShift <= {rxShift[FRAME_W-2:0], spiMiso};
      if (strobe.storeRes && expValid) begin
        if (tagMatch) countQ <= countQ + CNT_W'(1);
        else          errQ   <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [SLOT_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                slotQ <= '0;
      else if (strobe.latchCfg)                 slotQ <= '0;
      else if (storeOk && countQ == CNT_W'(g))  slotQ <= sample;
    end
    assign results[g*SLOT_W +: SLOT_W] = slotQ;
  end

  assign spiMosi   = txShift[FRAME_W-1];
  assign scanError = errQ;
  assign resCount  = countQ;

  // R6: never more valid slots than channels
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    resCount <= CNT_W'(NUM_CH))
    else $error("p_count_bound_r6");

  // R5: a mismatched tag leaves the count alone and flags the scan
  p_drop_mismatch_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.storeRes && expValid && !tagMatch) |=> ($stable(resCount) && scanError))
    else $error("p_drop_mismatch_r5");

  // R3: the pipeline tail frame carries no command
  p_tail_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadCmd && !cmdValid) |=> !spiMosi)
    else $error("p_tail_zero_r3");

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int CLK_DIV     = 2,
  parameter int CS_GAP_SCLK = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [NUM_CH-1:0]        chanMask,
  input  logic                     rangeSel,
  input  logic [1:0]               resSel,
  input  logic                     spiMiso,
  output logic                     spiSclk,
  output logic                     spiCsN,
  output logic                     spiMosi,
  output logic                     busy,
  output logic                     done,
  output logic                     scanError,
  output logic [CNT_W-1:0]         resCount,
  output logic [NUM_CH*SLOT_W-1:0] results
);

  scanStrobe_t     strobe;
  logic [CH_W-1:0] cmdChan;
  logic            cmdValid;

  adc_scan_seq #(
    .NUM_CH      (NUM_CH),
    .CLK_DIV     (CLK_DIV),
    .CS_GAP_SCLK (CS_GAP_SCLK)
  ) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .chanMask (chanMask),
    .strobe   (strobe),
    .cmdChan  (cmdChan),
    .cmdValid (cmdValid),
    .spiSclk  (spiSclk),
    .spiCsN   (spiCsN),
    .busy     (busy),
    .done     (done)
  );

  adc_scan_datapath #(
    .NUM_CH (NUM_CH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdChan   (cmdChan),
    .cmdValid  (cmdValid),
    .rangeSel  (rangeSel),
    .resSel    (resSel),
    .spiMiso   (spiMiso),
    .spiMosi   (spiMosi),
    .scanError (scanError),
    .resCount  (resCount),
    .results   (results)
  );

  // R2: MOSI holds while SCLK stays high inside a frame
  p_mosi_launch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && spiSclk && $past(spiSclk) && !$past(spiCsN)) |-> $stable(spiMosi))
    else $error("p_mosi_launch_r2");

  // R10: nothing toggles on the bus while idle
  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (spiCsN && spiSclk))
    else $error("p_idle_bus_r10");

endmodule

// File: tb/adc_scan_ctrl_tb.sv
`timescale 1ns/1ps
module adc_scan_ctrl_tb;

  localparam int NUM_CH = 8;
  localparam int NVEC   = 6;
  // {mask[14:7], range[6], res[5:4], corruptCh[3:0] (F = none)}
  localparam logic [14:0] VEC [NVEC] = '{
    {8'hFF, 1'b1, 2'd2, 4'hF},
    {8'h01, 1'b0, 2'd0, 4'hF},
    {8'hA5, 1'b1, 2'd1, 4'hF},
    {8'h80, 1'b0, 2'd2, 4'hF},
    {8'h3C, 1'b1, 2'd0, 4'h2},
    {8'h81, 1'b0, 2'd1, 4'h7}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  chanMask = '0;
  logic        rangeSel = 1'b0;
  logic [1:0]  resSel = 2'd2;
  logic        spiMiso = 1'b0;
  logic        spiSclk, spiCsN, spiMosi, busy, done, scanError;
  logic [3:0]  resCount;
  logic [NUM_CH*12-1:0] results;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  adc_scan_ctrl #(.NUM_CH(NUM_CH), .CLK_DIV(2), .CS_GAP_SCLK(2)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .chanMask(chanMask),
    .rangeSel(rangeSel), .resSel(resSel), .spiMiso(spiMiso),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .busy(busy), .done(done), .scanError(scanError),
    .resCount(resCount), .results(results)
  );

  always #5 clk = ~clk;

  // converter model
  logic [15:0] frameLog [16];
  int          frameCnt = 0;
  logic [15:0] mosiWord = '0;
  logic [15:0] respWord = 16'hF123;
  int          fallCnt = 0;
  logic [3:0]  corruptCh = 4'hF;
  time         lastRise = 0;
  longint      minGapNs = 1000000;
  int          donePulses = 0;

  function automatic logic [11:0] rawOf(input int ch);
    return 12'(12'h9C3 ^ (ch * 12'h157));
  endfunction

  always @(negedge spiCsN) begin
    mosiWord = '0;
    fallCnt  = 0;
    if (frameCnt > 0 && ($time - lastRise) < minGapNs) minGapNs = $time - lastRise;
  end

  always @(negedge spiSclk) begin
    if (!spiCsN) begin
      spiMiso = respWord[15 - fallCnt];
      fallCnt++;
    end
  end

  always @(posedge spiSclk) begin
    if (!spiCsN) mosiWord = {mosiWord[14:0], spiMosi};
  end

  always @(posedge spiCsN) begin
    if (frameCnt < 16) frameLog[frameCnt] = mosiWord;
    frameCnt++;
    lastRise = $time;
    if (mosiWord[15]) begin
      logic [3:0] ch;
      ch = {1'b0, mosiWord[12:10]};
      respWord = {(ch == corruptCh) ? (ch ^ 4'h8) : ch, rawOf(int'(ch))};
    end else begin
      respWord = 16'hF5A5;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (done) donePulses++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart(input logic [7:0] m, input logic r, input logic [1:0] s);
    @(negedge clk);
    chanMask = m; rangeSel = r; resSel = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic runScan(input logic [7:0] m, input logic r, input logic [1:0] s, input logic [3:0] bad);
    int n = 0, k = 0, nStored = 0, cmdBad = 0;
    logic errExp = 1'b0;
    logic [11:0] expSlot [NUM_CH];
    for (int i = 0; i < NUM_CH; i++) expSlot[i] = '0;
    corruptCh = bad;
    frameCnt = 0; minGapNs = 1000000; donePulses = 0;
    pulseStart(m, r, s);
    chk("R7", "busy after start", {31'b0, busy}, 32'd1);
    waitDone();
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (m[ch]) begin
        logic [15:0] expFrame;
        logic [11:0] raw;
        expFrame = {4'b1000 | 4'(ch >> 2), 2'(ch) , 2'b11, 1'b0, 1'b0, r, 1'b1, 4'b0};
        if (k < 16 && frameLog[k] !== expFrame) cmdBad++;
        k++; n++;
        raw = rawOf(ch);
        if (4'(ch) == bad) errExp = 1'b1;
        else begin
          expSlot[nStored] = (s == 2'd0) ? {4'b0, raw[11:4]} :
                             (s == 2'd1) ? {2'b0, raw[11:2]} : raw;
          nStored++;
        end
      end
    end
    chk("R1", "command frames wrong", cmdBad, 0);
    chk("R7", "done with busy low", {30'b0, done, busy}, 32'd2);
    chk("R6", "resCount", resCount, nStored);
    chk("R5", "scanError", scanError, errExp);
    for (int i = 0; i < NUM_CH; i++)
      chk(i < nStored ? "R4" : "R6", $sformatf("slot %0d", i), results[i*12 +: 12], expSlot[i]);
    repeat (30) @(negedge clk);
    chk("R3", "frame count", frameCnt, n + 1);
    chk("R3", "tail frame", frameLog[n], 16'h0000);
    chk("R7", "done pulses", donePulses, 1);
    chk("R2", "min cs gap ns", (minGapNs >= 80) ? 1 : 0, 1);
  endtask

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10", "csN", spiCsN, 1);
    chk("R10", "sclk", spiSclk, 1);
    chk("R10", "busy/done", {busy, done}, 0);
    chk("R10", "resCount", resCount, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      runScan(VEC[v][14:7], VEC[v][6], VEC[v][5:4], VEC[v][3:0]);

    // R9 empty mask
    frameCnt = 0; donePulses = 0;
    @(negedge clk);
    chanMask = 8'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "done next cycle", {30'b0, done, busy}, 32'd2);
    chk("R9", "count/error", {resCount, scanError}, 0);
    repeat (20) @(negedge clk);
    chk("R9", "no frames", frameCnt, 0);
    chk("R9", "single done", donePulses, 1);

    // R8 start while busy ignored
    corruptCh = 4'hF; frameCnt = 0; donePulses = 0;
    pulseStart(8'hFF, 1'b1, 2'd2);
    repeat (100) @(negedge clk);
    pulseStart(8'h01, 1'b0, 2'd0);
    waitDone();
    chk("R8", "count kept", resCount, 8);
    chk("R8", "slot 7 full res", results[7*12 +: 12], rawOf(7));
    repeat (40) @(negedge clk);
    chk("R8", "frames", frameCnt, 9);
    chk("R8", "done pulses", donePulses, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule